// File: doc/BRIEF.md
# Fault-Tolerant Negative-First Route Unit

This unit computes the output port for the head flit of a packet entering one switch of a two-dimensional mesh. It follows the negative-first turn model. While the destination lies west or south of the current switch, the packet heads west or south, and it may overshoot past the destination's column or row to get around a broken neighbour. Once the remaining travel is only east and north, it moves east or north and never turns back. When a broken switch sits on the south row or west column and blocks the way, the unit can step off that edge: a single sideways hop in the westward or southward phase, or a fixed four-hop loop in the eastward or northward phase.

The switch presents the current and destination coordinates, the last row and column index of the mesh, one fault flag per neighbour, the port the flit arrived on, and two header fields: a phase bit and a two-bit detour step. One cycle later the unit returns the chosen port, the rewritten header fields and an error flag. The detour step lets the loop continue across the next three switches without any state held in the switch.

Top module: `nf_route_unit`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_err, out_phase and out_step are 0 and out_port is 0 (local).
- R2: Port codes are 0 local, 1 north, 2 east, 3 south, 4 west; fault bits are [0] north, [1] east, [2] south, [3] west. When the destination equals the current position, the result is the local port with step 0, no error and the phase echoed.
- R3: A port is usable only if its fault bit is 0, it is not the arrival port, and it stays inside the mesh (north needs y below the last row, east needs x below the last column, south needs y above 0, west needs x above 0). With header step 0, phase 0 and a negative offset, both usable west and south are candidates even when that overshoots the destination; the result keeps phase 0 and step 0.
- R4: In that westward or southward case a move that reduces a negative offset beats an overshoot, then a move not landing on column 0 or row 0 beats one that does, then the larger remaining offset wins, then west beats south.
- R5: If no westward or southward candidate exists, on row 0 the unit sends north, otherwise on column 0 it sends east, when that port is usable; phase stays 0.
- R6: With both offsets non-negative and header step 0, the unit picks among usable east and north moves that reduce a positive offset: a move not reaching the destination's column or row wins, then the larger offset, then east; the result has phase 1.
- R7: If no such move exists, the destination and current switch are both on row 0, the east offset is at least 2 and north is usable, the unit sends north with step 1; symmetrically on column 0 with north offset at least 2 it sends east with step 1. With a nonzero header step it continues the loop: steps 1 and 2 go east (destination on row 0) or north (otherwise), step 3 goes south or west respectively; the step advances modulo 4 and the phase is 1.
- R8: With header phase 1 and a negative offset, the result is an error; a phase of 1 is never cleared.
- R9: The result is never the arrival port.
- R10: When no usable port exists under the rules above, out_err is 1, out_port is local and the header phase and step are echoed.
- R11: Each result appears one clock after its request; out_valid is in_valid delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| cur_x | input | 4 | Column of this switch |
| cur_y | input | 4 | Row of this switch |
| dst_x | input | 4 | Destination column |
| dst_y | input | 4 | Destination row |
| max_x | input | 4 | Index of the last column |
| max_y | input | 4 | Index of the last row |
| nbr_fault | input | 4 | Faulty neighbour flags: [0] N, [1] E, [2] S, [3] W |
| in_dir | input | 3 | Arrival port code, 0 when injected locally |
| hdr_phase | input | 1 | Header phase bit, 1 once an eastward or northward move has been made |
| hdr_step | input | 2 | Header detour step |
| out_valid | output | 1 | Result present |
| out_port | output | 3 | Selected port code |
| out_phase | output | 1 | Phase bit to write back |
| out_step | output | 2 | Detour step to write back |
| out_err | output | 1 | No usable port exists |

## Verification
The assertions take for granted that the current and destination coordinates lie inside the mesh given by max_x and max_y, and that in_valid is low while reset is held. The random stimulus draws the mesh bounds first and then draws both positions within them, keeping in_valid low during reset. Phase, step, arrival port and fault flags are drawn freely, since every combination of them has a defined result, including the error.

// File: rtl/nf_route_pkg.sv
// Shared definitions for the negative-first route unit.
// Assumes port codes are fixed because the switch crossbar decodes them.
package nf_route_pkg;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_N     = 3'd1,
        PORT_E     = 3'd2,
        PORT_S     = 3'd3,
        PORT_W     = 3'd4
    } port_e;

    // Bit positions in the neighbour fault and usability vectors
    localparam int DIR_N = 0;
    localparam int DIR_E = 1;
    localparam int DIR_S = 2;
    localparam int DIR_W = 3;
    localparam int NUM_DIRS = 4;

    // Detour step counter width (four-hop loop)
    localparam int STEP_W = 2;

    typedef struct packed {
        port_e             port;
        logic              phase;
        logic [STEP_W-1:0] step;
        logic              err;
    } route_s;

endpackage

// File: rtl/nf_offset_calc.sv
// Offset calculator: signed distance to the destination on each axis,
// split into four unsigned magnitudes (one per travel direction).
// Assumes both positions fit in COORD_W bits; a magnitude is zero when
// the destination does not lie in that direction.
module nf_offset_calc #(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0]        cur_x,
    input  logic [COORD_W-1:0]        cur_y,
    input  logic [COORD_W-1:0]        dst_x,
    input  logic [COORD_W-1:0]        dst_y,
    output logic signed [COORD_W:0]   off_x,
    output logic signed [COORD_W:0]   off_y,
    output logic [COORD_W-1:0]        mag_w,
    output logic [COORD_W-1:0]        mag_s,
    output logic [COORD_W-1:0]        mag_e,
    output logic [COORD_W-1:0]        mag_n
);

    logic signed [COORD_W:0] neg_x;
    logic signed [COORD_W:0] neg_y;

    // Signed offsets and per-direction magnitudes
    always_comb begin
        off_x = $signed({1'b0, dst_x}) - $signed({1'b0, cur_x});
        off_y = $signed({1'b0, dst_y}) - $signed({1'b0, cur_y});
        neg_x = -off_x;
        neg_y = -off_y;
        mag_w = off_x[COORD_W] ? neg_x[COORD_W-1:0] : '0;
        mag_e = off_x[COORD_W] ? '0 : off_x[COORD_W-1:0];
        mag_s = off_y[COORD_W] ? neg_y[COORD_W-1:0] : '0;
        mag_n = off_y[COORD_W] ? '0 : off_y[COORD_W-1:0];
    end

endmodule

// File: rtl/nf_neg_select.sv
// Westward/southward selector for the negative phase.
// Ranks each usable candidate by a packed key: offset still needed,
// not landing on a negative edge, remaining magnitude, west bias.
// Assumes the caller only uses the result when a negative offset exists.
module nf_neg_select
    import nf_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               avail_w,
    input  logic               avail_s,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] mag_w,
    input  logic [COORD_W-1:0] mag_s,
    output logic               found,
    output port_e              port
);

    localparam int KEY_W = COORD_W + 3;
    localparam logic [COORD_W-1:0] ONE = {{(COORD_W-1){1'b0}}, 1'b1};

    logic [KEY_W-1:0] key_w;
    logic [KEY_W-1:0] key_s;

    // Build ranking keys; the last bit breaks ties toward west
    always_comb begin
        key_w = {|mag_w, cur_x != ONE, mag_w, 1'b1};
        key_s = {|mag_s, cur_y != ONE, mag_s, 1'b0};
    end

    // Pick the best usable candidate
    always_comb begin
        found = avail_w | avail_s;
        if (avail_w && (!avail_s || key_w > key_s)) begin
            port = PORT_W;
        end else if (avail_s) begin
            port = PORT_S;
        end else begin
            port = PORT_LOCAL;
        end
    end

endmodule

// File: rtl/nf_pos_select.sv
// Eastward/northward selector for the positive phase.
// Only moves that shrink a positive offset are candidates; a move that
// would not yet reach the destination column/row ranks first, then the
// larger magnitude, then east.
module nf_pos_select
    import nf_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               avail_e,
    input  logic               avail_n,
    input  logic [COORD_W-1:0] mag_e,
    input  logic [COORD_W-1:0] mag_n,
    output logic               found,
    output port_e              port
);

    localparam int KEY_W = COORD_W + 2;
    localparam logic [COORD_W-1:0] ONE = {{(COORD_W-1){1'b0}}, 1'b1};

    logic             cand_e;
    logic             cand_n;
    logic [KEY_W-1:0] key_e;
    logic [KEY_W-1:0] key_n;

    // Candidate qualification and ranking keys
    always_comb begin
        cand_e = avail_e && (|mag_e);
        cand_n = avail_n && (|mag_n);
        key_e  = {mag_e != ONE, mag_e, 1'b1};
        key_n  = {mag_n != ONE, mag_n, 1'b0};
    end

    // Pick the best candidate
    always_comb begin
        found = cand_e | cand_n;
        if (cand_e && (!cand_n || key_e > key_n)) begin
            port = PORT_E;
        end else if (cand_n) begin
            port = PORT_N;
        end else begin
            port = PORT_LOCAL;
        end
    end

endmodule

// File: rtl/nf_detour.sv
// Edge-detour sequencer: continues the four-hop loop around a fault on a
// negative edge. Steps 1 and 2 run parallel to the edge, step 3 returns
// onto it. Assumes step is nonzero when the result is used.
module nf_detour
    import nf_route_pkg::*;
(
    input  logic [STEP_W-1:0]   step,
    input  logic                row_case,
    input  logic [NUM_DIRS-1:0] avail,
    output port_e               port,
    output logic [STEP_W-1:0]   nxt_step,
    output logic                ok
);

    localparam logic [STEP_W-1:0] LAST = '1;

    // Hop direction for the current step and its usability
    always_comb begin
        if (step == LAST) begin
            port = row_case ? PORT_S : PORT_W;
            ok   = row_case ? avail[DIR_S] : avail[DIR_W];
        end else begin
            port = row_case ? PORT_E : PORT_N;
            ok   = row_case ? avail[DIR_E] : avail[DIR_N];
        end
        nxt_step = step + 1'b1;
    end

endmodule

// File: rtl/nf_route_unit.sv
// Fault-tolerant negative-first route unit for one mesh switch.
// Combines usability masking, the two phase selectors, edge escapes and
// the detour loop into one routing decision, registered once.
// Assumes current and destination positions lie inside the mesh.
module nf_route_unit
    import nf_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] max_x,
    input  logic [COORD_W-1:0] max_y,
    input  logic [3:0]         nbr_fault,
    input  logic [2:0]         in_dir,
    input  logic               hdr_phase,
    input  logic [1:0]         hdr_step,
    output logic               out_valid,
    output logic [2:0]         out_port,
    output logic               out_phase,
    output logic [1:0]         out_step,
    output logic               out_err
);

    localparam logic [COORD_W-1:0] TWO = {{(COORD_W-2){1'b0}}, 2'b10};

    logic signed [COORD_W:0] off_x;
    logic signed [COORD_W:0] off_y;
    logic [COORD_W-1:0]      mag_w, mag_s, mag_e, mag_n;
    logic [NUM_DIRS-1:0]     in_mesh;
    logic [NUM_DIRS-1:0]     avail;
    logic                    neg_found, pos_found, det_ok;
    port_e                   neg_port, pos_port, det_port;
    logic [STEP_W-1:0]       det_step;
    logic                    any_neg;
    route_s                  nxt;
    route_s                  res_q;

    nf_offset_calc #(.COORD_W(COORD_W)) u_offset (
        .cur_x (cur_x), .cur_y (cur_y), .dst_x (dst_x), .dst_y (dst_y),
        .off_x (off_x), .off_y (off_y),
        .mag_w (mag_w), .mag_s (mag_s), .mag_e (mag_e), .mag_n (mag_n)
    );

    // Which neighbours exist inside the mesh boundary
    always_comb begin
        in_mesh[DIR_N] = cur_y < max_y;
        in_mesh[DIR_E] = cur_x < max_x;
        in_mesh[DIR_S] = cur_y != '0;
        in_mesh[DIR_W] = cur_x != '0;
    end

    // A port is usable if healthy, inside the mesh and not the arrival port
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_avail
        assign avail[d] = !nbr_fault[d] && in_mesh[d] && (in_dir != 3'(d + 1));
    end

    nf_neg_select #(.COORD_W(COORD_W)) u_neg (
        .avail_w (avail[DIR_W]), .avail_s (avail[DIR_S]),
        .cur_x (cur_x), .cur_y (cur_y), .mag_w (mag_w), .mag_s (mag_s),
        .found (neg_found), .port (neg_port)
    );

    nf_pos_select #(.COORD_W(COORD_W)) u_pos (
        .avail_e (avail[DIR_E]), .avail_n (avail[DIR_N]),
        .mag_e (mag_e), .mag_n (mag_n),
        .found (pos_found), .port (pos_port)
    );

    nf_detour u_detour (
        .step (hdr_step), .row_case (dst_y == '0), .avail (avail),
        .port (det_port), .nxt_step (det_step), .ok (det_ok)
    );

    // Routing decision across arrival, detour, negative and positive cases
    always_comb begin
        any_neg = off_x[COORD_W] | off_y[COORD_W];
        nxt     = '{port: PORT_LOCAL, phase: hdr_phase, step: hdr_step, err: 1'b1};
        if (off_x == '0 && off_y == '0) begin
            nxt.step = '0;
            nxt.err  = 1'b0;
        end else if (hdr_step != '0) begin
            if (det_ok) begin
                nxt = '{port: det_port, phase: 1'b1, step: det_step, err: 1'b0};
            end
        end else if (any_neg) begin
            if (hdr_phase) begin
                nxt.err = 1'b1;
            end else if (neg_found) begin
                nxt = '{port: neg_port, phase: 1'b0, step: '0, err: 1'b0};
            end else if (cur_y == '0 && avail[DIR_N]) begin
                nxt = '{port: PORT_N, phase: 1'b0, step: '0, err: 1'b0};
            end else if (cur_x == '0 && avail[DIR_E]) begin
                nxt = '{port: PORT_E, phase: 1'b0, step: '0, err: 1'b0};
            end
        end else begin
            if (pos_found) begin
                nxt = '{port: pos_port, phase: 1'b1, step: '0, err: 1'b0};
            end else if (off_y == '0 && dst_y == '0 && mag_e >= TWO && avail[DIR_N]) begin
                nxt = '{port: PORT_N, phase: 1'b1, step: 2'd1, err: 1'b0};
            end else if (off_x == '0 && dst_x == '0 && mag_n >= TWO && avail[DIR_E]) begin
                nxt = '{port: PORT_E, phase: 1'b1, step: 2'd1, err: 1'b0};
            end
        end
    end

    // Result register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_q     <= '{port: PORT_LOCAL, phase: 1'b0, step: '0, err: 1'b0};
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= nxt;
            end
        end
    end

    assign out_port  = res_q.port;
    assign out_phase = res_q.phase;
    assign out_step  = res_q.step;
    assign out_err   = res_q.err;

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_arrive_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_x == dst_x && cur_y == dst_y) |=> (out_port == 3'd0 && !out_err));

    p_west_usable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port == 3'd4) |-> ($past(cur_x) != '0 && !$past(nbr_fault[3])));

    p_north_usable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port == 3'd1) |-> ($past(cur_y) < $past(max_y) && !$past(nbr_fault[0])));

    p_phase_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hdr_phase) |=> (out_err || out_phase));

    p_no_uturn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dir != 3'd0) |=> (out_port != $past(in_dir)));

    p_err_local_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_port == 3'd0));

endmodule

// File: tb/nf_route_unit_bench.sv
// Bench for nf_route_unit: directed corner cases then seeded random vectors,
// each compared with an independent routing model.
module nf_route_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [3:0] cur_x, cur_y, dst_x, dst_y, max_x, max_y;
    logic [3:0] nbr_fault;
    logic [2:0] in_dir;
    logic       hdr_phase;
    logic [1:0] hdr_step;
    logic       out_valid;
    logic [2:0] out_port;
    logic       out_phase;
    logic [1:0] out_step;
    logic       out_err;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nf_route_unit u_nf_route_unit (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .cur_x (cur_x), .cur_y (cur_y), .dst_x (dst_x), .dst_y (dst_y),
        .max_x (max_x), .max_y (max_y), .nbr_fault (nbr_fault),
        .in_dir (in_dir), .hdr_phase (hdr_phase), .hdr_step (hdr_step),
        .out_valid (out_valid), .out_port (out_port), .out_phase (out_phase),
        .out_step (out_step), .out_err (out_err)
    );

    // Reference model: {port[2:0], phase, step[1:0], err}
    function automatic logic [6:0] model(int cx, int cy, int tx, int ty, int mx, int my,
                                         logic [3:0] flt, int idir, logic ph, int st);
        int  ox = tx - cx;
        int  oy = ty - cy;
        bit  ok [1:4];
        int  best = 0;
        int  score = -1;
        int  sc, mag;
        logic [6:0] bad = {3'd0, ph, 2'(st), 1'b1};
        ok[1] = !flt[0] && cy < my && idir != 1;
        ok[2] = !flt[1] && cx < mx && idir != 2;
        ok[3] = !flt[2] && cy > 0  && idir != 3;
        ok[4] = !flt[3] && cx > 0  && idir != 4;
        if (ox == 0 && oy == 0) return {3'd0, ph, 2'd0, 1'b0};
        if (st != 0) begin
            int p;
            if (st == 3) p = (ty == 0) ? 3 : 4;
            else         p = (ty == 0) ? 2 : 1;
            if (ok[p]) return {3'(p), 1'b1, 2'((st + 1) % 4), 1'b0};
            return bad;
        end
        if (ox < 0 || oy < 0) begin
            if (ph) return bad;
            for (int p = 3; p <= 4; p++) begin
                if (ok[p]) begin
                    mag = (p == 4) ? ((ox < 0) ? -ox : 0) : ((oy < 0) ? -oy : 0);
                    sc  = ((mag > 0) ? 1000 : 0)
                        + ((((p == 4) ? cx : cy) != 1) ? 100 : 0)
                        + mag * 2 + ((p == 4) ? 1 : 0);
                    if (sc > score) begin score = sc; best = p; end
                end
            end
            if (best != 0) return {3'(best), 1'b0, 2'd0, 1'b0};
            if (cy == 0 && ok[1]) return {3'd1, 1'b0, 2'd0, 1'b0};
            if (cx == 0 && ok[2]) return {3'd2, 1'b0, 2'd0, 1'b0};
            return bad;
        end
        for (int p = 1; p <= 2; p++) begin
            mag = (p == 2) ? ox : oy;
            if (ok[p] && mag > 0) begin
                sc = ((mag != 1) ? 100 : 0) + mag * 2 + ((p == 2) ? 1 : 0);
                if (sc > score) begin score = sc; best = p; end
            end
        end
        if (best != 0) return {3'(best), 1'b1, 2'd0, 1'b0};
        if (oy == 0 && ty == 0 && ox >= 2 && ok[1]) return {3'd1, 1'b1, 2'd1, 1'b0};
        if (ox == 0 && tx == 0 && oy >= 2 && ok[2]) return {3'd2, 1'b1, 2'd1, 1'b0};
        return bad;
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid/port/phase/step/err=%b expected %b", tag, got, exp);
        end
    endtask

    // Apply one request, then compare the registered result one clock later
    task automatic run_vec(string tag, int cx, int cy, int tx, int ty, int mx, int my,
                           logic [3:0] flt, int idir, logic ph, int st);
        logic [6:0] exp;
        @(negedge clk);
        cur_x = 4'(cx); cur_y = 4'(cy); dst_x = 4'(tx); dst_y = 4'(ty);
        max_x = 4'(mx); max_y = 4'(my); nbr_fault = flt; in_dir = 3'(idir);
        hdr_phase = ph; hdr_step = 2'(st); in_valid = 1'b1;
        exp = model(cx, cy, tx, ty, mx, my, flt, idir, ph, st);
        @(negedge clk);
        check(tag, {out_valid, out_port, out_phase, out_step, out_err}, {1'b1, exp});
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R11: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        rst_n = 1'b0; in_valid = 1'b0;
        cur_x = '0; cur_y = '0; dst_x = '0; dst_y = '0; max_x = 4'd7; max_y = 4'd7;
        nbr_fault = '0; in_dir = '0; hdr_phase = 1'b0; hdr_step = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {out_valid, out_port, out_phase, out_step, out_err}, 8'd0);

        // R2 arrival
        run_vec("R2 arrive local",       5, 5, 5, 5, 7, 7, 4'h0, 0, 1'b1, 0);
        // R4 larger westward need wins
        run_vec("R4 larger need west",   6, 6, 2, 4, 7, 7, 4'h0, 0, 1'b0, 0);
        run_vec("R4 tie west",           5, 5, 3, 3, 7, 7, 4'h0, 0, 1'b0, 0);
        run_vec("R4 edge avoided south", 1, 5, 0, 2, 7, 7, 4'h0, 0, 1'b0, 0);
        // R3 overshoot south past destination row
        run_vec("R3 overshoot south",    5, 5, 3, 7, 7, 7, 4'h8, 0, 1'b0, 0);
        // R5 edge escapes
        run_vec("R5 row0 escape north",  5, 0, 2, 0, 7, 7, 4'h8, 0, 1'b0, 0);
        run_vec("R5 col0 escape east",   0, 5, 0, 1, 7, 7, 4'h4, 0, 1'b0, 0);
        // R6 positive phase
        run_vec("R6 east first",         2, 2, 5, 3, 7, 7, 4'h0, 0, 1'b0, 0);
        run_vec("R6 north not reaching", 2, 2, 3, 6, 7, 7, 4'h0, 0, 1'b0, 0);
        run_vec("R6 tie east",           2, 2, 4, 4, 7, 7, 4'h0, 3, 1'b1, 0);
        // R7 detour start and continuation
        run_vec("R7 row detour start",   1, 0, 5, 0, 7, 7, 4'h2, 0, 1'b0, 0);
        run_vec("R7 row detour step1",   1, 1, 5, 0, 7, 7, 4'h0, 3, 1'b1, 1);
        run_vec("R7 row detour step3",   3, 1, 5, 0, 7, 7, 4'h0, 4, 1'b1, 3);
        run_vec("R7 col detour start",   0, 1, 0, 6, 7, 7, 4'h1, 0, 1'b0, 0);
        // R10 errors
        run_vec("R10 detour too short",  4, 0, 5, 0, 7, 7, 4'h2, 0, 1'b0, 0);
        run_vec("R10 all blocked",       5, 5, 2, 2, 7, 7, 4'hC, 0, 1'b0, 0);
        // R8 no return to negative directions
        run_vec("R8 phase sticky error", 5, 5, 2, 2, 7, 7, 4'h0, 0, 1'b1, 0);
        // R9 arrival port excluded
        run_vec("R9 no u-turn",          5, 5, 2, 2, 7, 7, 4'h0, 4, 1'b0, 0);

        // R11 idle cycle keeps out_valid low
        @(negedge clk);
        check("R11 idle", {7'd0, out_valid}, 8'd0);

        for (int i = 0; i < 3000; i++) begin
            int mx = 1 + int'($urandom % 15);
            int my = 1 + int'($urandom % 15);
            int cx = int'($urandom % (mx + 1));
            int cy = int'($urandom % (my + 1));
            int tx = int'($urandom % (mx + 1));
            int ty = int'($urandom % (my + 1));
            int st = (($urandom % 4) == 0) ? int'($urandom % 4) : 0;
            run_vec("R3 R6 R7 random", cx, cy, tx, ty, mx, my, 4'($urandom),
                    int'($urandom % 5), 1'($urandom), st);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule